// File: doc/BRIEF.md
# Serial Register Preload and Observe Chain

This block owns the full set of state registers of a programmable logic array and adds a test path that threads all of them into a single serial shift chain. In normal operation the registers capture their functional next-state word on a load strobe. In test mode the functional path is frozen and each rising edge of a slow scan clock shifts one bit into the head of the chain. Every register hands its bit on to its successor, and the bit at the tail is presented on a data-out pin whose driver can be switched off.

The register image is split into equal quadrants. Each quadrant holds a set of I/O-cell register pairs (a first and a second register per cell) and a set of buried registers. The chain runs through the quadrants in ascending order, and inside a quadrant the buried registers are woven in between the I/O-cell pairs. With a default of four quadrants, each with 13 cell pairs and 6 buried registers, the chain is 128 registers long. A full preload or a full unload therefore takes 128 scan pulses. Wiring data-out back to data-in reads the whole state without disturbing it. A security input disables the test path entirely.

Top module: `scan_preload_chain`

## Requirements
- R1: While `rstN` is low every register in `regQ` clears to 0, test mode is inactive and `scanDoutEn` is 0.
- R2: While test mode is inactive, a high `funcLoad` at a clock edge copies `funcD` into `regQ`. Pulses on `scanClk` have no effect on `regQ`.
- R3: The test-mode state follows `scanMode` only at a clock edge where both `scanClk` and `funcLoad` are low. A change of `scanMode` made while either of them is high is not acted on until both are low.
- R4: While test mode is active, each low-to-high transition of `scanClk`, as seen at a clock edge, performs exactly one shift. Chain position 0 takes `scanDin` exactly (1 loads 1, 0 loads 0), and position p takes the old value of position p-1. Holding `scanClk` high gives no further shift.
- R5: Chain position p maps to a register index as follows. Let q = p / R and r = p mod R, where R = 2*IO_CELLS + BURIED. Inside a quadrant the order is: first and second register of cell 0 (register indices qR+0 and qR+1); then cell 1 (qR+2, qR+3); then buried register 0 (qR+2*IO_CELLS+0); then cell 2; cell 3; buried register 1; and so on. So buried register b follows cell 2b+1, and any buried registers left over come after the last cell.
- R6: While test mode is active and `scanOeN` is low, `scanDoutEn` is 1 and `scanDout` equals the register at the last chain position. Bits therefore leave first-in first-out: after a full preload, the first bit shifted in is the first bit read out. With data-out looped back to data-in, a full unload leaves `regQ` unchanged.
- R7: While `scanOeN` is high, `scanDoutEn` and `scanDout` are both 0, and shifting continues (preload only).
- R8: While `secureLock` is high, no shift occurs, `scanDoutEn` is 0 and test mode is cleared. After the lock is released, test mode has to be entered again under R3.
- R9: While test mode is active, `funcLoad` has no effect on `regQ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset (power-up clear) |
| scanMode | input | 1 | Request for test mode |
| scanClk | input | 1 | Scan shift clock, edge-detected on `clk` |
| scanDin | input | 1 | Serial data into chain position 0 |
| scanOeN | input | 1 | High keeps data-out undriven |
| secureLock | input | 1 | Security state; high disables the test path |
| funcLoad | input | 1 | Functional register clock enable |
| funcD | input | NUM_REGS | Functional next-state word |
| regQ | output | NUM_REGS | Parallel register image |
| scanDout | output | 1 | Serial data from the last chain position |
| scanDoutEn | output | 1 | Drive enable for `scanDout` |

## Verification
A chain link that is wired to the wrong register shows up as a mismatch in `regQ` one cycle after the shift that uses it, and the serial stream out of `scanDout` carries the same misordering on the following scan pulse. A test-mode flag that is stuck or updates at the wrong moment shows up at once on `scanDoutEn`. It also shows up as functional loads that are wrongly accepted or wrongly dropped on the next edge. A missing edge detect on `scanClk` gives repeated shifts within the same held pulse, which the every-cycle comparison of the image catches on the second cycle of that pulse.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic doutEn;
  } scanStrobe_t;

  // Map a chain position to a register index in the parallel image.
  function automatic int chainToReg(input int p, input int ioCells, input int buried);
    int perQuad;
    int base;
    int r;
    int pos;
    int res;
    perQuad = 2 * ioCells + buried;
    base    = (p / perQuad) * perQuad;
    r       = p % perQuad;
    pos     = 0;
    res     = base;
    for (int c = 0; c < ioCells; c++) begin
      if (pos == r) res = base + 2 * c;
      pos++;
      if (pos == r) res = base + 2 * c + 1;
      pos++;
      if ((c % 2 == 1) && (c / 2 < buried)) begin
        if (pos == r) res = base + 2 * ioCells + c / 2;
        pos++;
      end
    end
    for (int b = 0; b < buried; b++) begin
      if (b > (ioCells - 2) / 2 || ioCells < 2) begin
        if (pos == r) res = base + 2 * ioCells + b;
        pos++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        scanMode,
  input  logic        scanClk,
  input  logic        scanOeN,
  input  logic        secureLock,
  input  logic        funcLoad,
  output scanStrobe_t strobe
);

  logic scanClkQ;
  logic modeActive;
  logic modeLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanClkQ   <= 1'b0;
      modeActive <= 1'b0;
    end else begin
      scanClkQ <= scanClk;
      if (secureLock) begin
        modeActive <= 1'b0;
      end else if (!scanClk && !funcLoad) begin
        modeActive <= scanMode;
      end
    end
  end

  assign modeLive = modeActive & ~secureLock;

  always_comb begin
    strobe.shiftEn = modeLive & scanClk & ~scanClkQ;
    strobe.loadEn  = ~modeLive & funcLoad;
    strobe.doutEn  = modeLive & ~scanOeN;
  end

endmodule

// File: rtl/scan_chain_datapath.sv
module scan_chain_datapath
  import scan_chain_pkg::*;
#(
  parameter int NUM_QUAD = 4,
  parameter int IO_CELLS = 13,
  parameter int BURIED   = 6,
  localparam int REGS_PER_QUAD = 2 * IO_CELLS + BURIED,
  localparam int NUM_REGS      = NUM_QUAD * REGS_PER_QUAD
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanStrobe_t         strobe,
  input  logic                scanDin,
  input  logic [NUM_REGS-1:0] funcD,
  output logic [NUM_REGS-1:0] regQ,
  output logic                tailBit
);

  localparam int TAIL_IDX = chainToReg(NUM_REGS - 1, IO_CELLS, BURIED);

  logic [NUM_REGS-1:0] shiftNext;

  for (genvar p = 0; p < NUM_REGS; p++) begin : g_link
    localparam int DST = chainToReg(p, IO_CELLS, BURIED);
    if (p == 0) begin : g_head
      assign shiftNext[DST] = scanDin;
    end else begin : g_body
      localparam int SRC = chainToReg(p - 1, IO_CELLS, BURIED);
      assign shiftNext[DST] = regQ[SRC];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (strobe.shiftEn) begin
      regQ <= shiftNext;
    end else if (strobe.loadEn) begin
      regQ <= funcD;
    end
  end

  assign tailBit = regQ[TAIL_IDX];

endmodule

// File: rtl/scan_preload_chain.sv
module scan_preload_chain
  import scan_chain_pkg::*;
#(
  parameter int NUM_QUAD = 4,
  parameter int IO_CELLS = 13,
  parameter int BURIED   = 6,
  localparam int NUM_REGS = NUM_QUAD * (2 * IO_CELLS + BURIED)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scanMode,
  input  logic                scanClk,
  input  logic                scanDin,
  input  logic                scanOeN,
  input  logic                secureLock,
  input  logic                funcLoad,
  input  logic [NUM_REGS-1:0] funcD,
  output logic [NUM_REGS-1:0] regQ,
  output logic                scanDout,
  output logic                scanDoutEn
);

  scanStrobe_t strobe;
  logic        tailBit;

  scan_chain_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .scanMode   (scanMode),
    .scanClk    (scanClk),
    .scanOeN    (scanOeN),
    .secureLock (secureLock),
    .funcLoad   (funcLoad),
    .strobe     (strobe)
  );

  scan_chain_datapath #(
    .NUM_QUAD (NUM_QUAD),
    .IO_CELLS (IO_CELLS),
    .BURIED   (BURIED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .scanDin (scanDin),
    .funcD   (funcD),
    .regQ    (regQ),
    .tailBit (tailBit)
  );

  assign scanDoutEn = strobe.doutEn;
  assign scanDout   = strobe.doutEn & tailBit;

endmodule

// File: rtl/scan_chain_chk.sv
module scan_chain_chk
  import scan_chain_pkg::*;
#(
  parameter int NUM_QUAD = 4,
  parameter int IO_CELLS = 13,
  parameter int BURIED   = 6,
  localparam int NUM_REGS = NUM_QUAD * (2 * IO_CELLS + BURIED)
) (
  input logic                clk,
  input logic                rstN,
  input logic                scanDin,
  input logic                scanOeN,
  input logic                secureLock,
  input logic [NUM_REGS-1:0] funcD,
  input logic [NUM_REGS-1:0] regQ,
  input logic                scanDout,
  input logic                scanDoutEn,
  input scanStrobe_t         strobe
);

  localparam int HEAD_IDX = chainToReg(0, IO_CELLS, BURIED);
  localparam int TAIL_IDX = chainToReg(NUM_REGS - 1, IO_CELLS, BURIED);
  localparam int PRE_IDX  = chainToReg(NUM_REGS - 2, IO_CELLS, BURIED);

  // R2: a functional load lands the whole word
  a_r2_func_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> regQ == $past(funcD));

  // R4: head of chain takes the serial input
  a_r4_head_din: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> regQ[HEAD_IDX] == $past(scanDin));

  // R4: one shift per scan pulse
  a_r4_single_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);

  // R5: last link carries the second-last position into the tail
  a_r5_tail_link: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> regQ[TAIL_IDX] == $past(regQ[PRE_IDX]));

  // R6: serial output shows the tail register
  a_r6_dout_tail: assert property (@(posedge clk) disable iff (!rstN)
    scanDoutEn |-> scanDout == regQ[TAIL_IDX]);

  // R7: output enable control keeps data-out quiet
  a_r7_oe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    scanOeN |-> (!scanDoutEn && !scanDout));

  // R8: security state blocks shift and observe
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    secureLock |-> (!scanDoutEn && !strobe.shiftEn));

  // R9: without a strobe the image holds
  a_r9_image_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.shiftEn && !strobe.loadEn) |=> $stable(regQ));

endmodule

bind scan_preload_chain scan_chain_chk #(
  .NUM_QUAD (NUM_QUAD),
  .IO_CELLS (IO_CELLS),
  .BURIED   (BURIED)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .scanDin    (scanDin),
  .scanOeN    (scanOeN),
  .secureLock (secureLock),
  .funcD      (funcD),
  .regQ       (regQ),
  .scanDout   (scanDout),
  .scanDoutEn (scanDoutEn),
  .strobe     (strobe)
);

// File: tb/sim_scan_preload_chain.sv
`timescale 1ns/1ps
module sim_scan_preload_chain;

  localparam int NQ  = 4;
  localparam int IOC = 13;
  localparam int BUR = 6;
  localparam int PQ  = 2 * IOC + BUR;
  localparam int N   = NQ * PQ;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         scanMode = 1'b0;
  logic         scanClk = 1'b0;
  logic         scanDin = 1'b0;
  logic         scanOeN = 1'b0;
  logic         secureLock = 1'b0;
  logic         funcLoad = 1'b0;
  logic [N-1:0] funcD = '0;
  logic [N-1:0] regQ;
  logic         scanDout;
  logic         scanDoutEn;

  always #2.5 clk = ~clk;

  scan_preload_chain u0 (
    .clk(clk), .rstN(rstN), .scanMode(scanMode), .scanClk(scanClk),
    .scanDin(scanDin), .scanOeN(scanOeN), .secureLock(secureLock),
    .funcLoad(funcLoad), .funcD(funcD), .regQ(regQ),
    .scanDout(scanDout), .scanDoutEn(scanDoutEn)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // chain order built from the written rule in R5
  int ord[N];
  initial begin
    int k;
    k = 0;
    for (int q = 0; q < NQ; q++) begin
      int nextBur;
      nextBur = 0;
      for (int c = 0; c < IOC; c++) begin
        ord[k] = q * PQ + 2 * c;     k++;
        ord[k] = q * PQ + 2 * c + 1; k++;
        if (c % 2 == 1 && nextBur < BUR) begin
          ord[k] = q * PQ + 2 * IOC + nextBur; k++; nextBur++;
        end
      end
      while (nextBur < BUR) begin
        ord[k] = q * PQ + 2 * IOC + nextBur; k++; nextBur++;
      end
    end
  end

  // reference model: queue in chain order, index 0 = head
  bit chainQ[$];
  bit mMode = 0;
  bit mPrevSc = 0;

  initial for (int i = 0; i < N; i++) chainQ.push_back(1'b0);

  always @(posedge clk) begin
    bit live;
    if (!rstN) begin
      for (int i = 0; i < N; i++) chainQ[i] = 1'b0;
      mMode = 0; mPrevSc = 0;
    end else begin
      live = mMode && !secureLock;
      if (live && scanClk && !mPrevSc) begin
        chainQ.push_front(scanDin);
        void'(chainQ.pop_back());
      end else if (!live && funcLoad) begin
        for (int i = 0; i < N; i++) chainQ[i] = funcD[ord[i]];
      end
      mPrevSc = scanClk;
      if (secureLock) mMode = 0;
      else if (!scanClk && !funcLoad) mMode = scanMode;
    end
  end

  task automatic check1(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    bit expEn;
    bit mismatch;
    if (rstN) begin
      expEn = mMode && !secureLock && !scanOeN;
      check1(curReq, scanDoutEn, expEn, "scanDoutEn");
      check1(curReq, scanDout, expEn ? chainQ[N-1] : 1'b0, "scanDout");
      mismatch = 0;
      for (int i = 0; i < N; i++) if (regQ[ord[i]] !== chainQ[i]) mismatch = 1;
      checks++;
      if (mismatch) begin
        errors++;
        $display("FAIL %s regQ actual=%h expected image differs", curReq, regQ);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse(input logic din);
    scanDin = din; scanClk = 1'b1;
    tick(2);
    scanClk = 1'b0;
    tick(2);
  endtask

  logic [31:0] rng = 32'h1d2c3b4a;
  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  bit pat[N];
  logic [N-1:0] snap;

  initial begin
    // R1 reset
    tick(3);
    check1("R1", scanDoutEn, 1'b0, "reset scanDoutEn");
    checks++; if (regQ !== '0) begin errors++; $display("FAIL R1 regQ actual=%h expected=0", regQ); end
    rstN = 1'b1; tick(1);

    // R2 functional load and ignored scan pulses
    curReq = "R2";
    for (int k = 0; k < 3; k++) begin
      rng = nextRng(rng);
      funcD = {4{rng}} ^ (N'(k) << 7);
      funcLoad = 1'b1; tick(1); funcLoad = 1'b0; tick(1);
      checks++; if (regQ !== funcD) begin errors++; $display("FAIL R2 regQ actual=%h expected=%h", regQ, funcD); end
    end
    snap = regQ;
    pulse(1'b1); pulse(1'b0);
    checks++; if (regQ !== snap) begin errors++; $display("FAIL R2 scan pulse changed regQ actual=%h expected=%h", regQ, snap); end

    // R3 entry blocked while scanClk high
    curReq = "R3";
    scanClk = 1'b1; tick(1); scanMode = 1'b1; tick(3);
    check1("R3", scanDoutEn, 1'b0, "entry with scanClk high");
    scanClk = 1'b0; tick(2);
    check1("R3", scanDoutEn, 1'b1, "entry with clocks low");

    // R4 R5 preload
    curReq = "R4";
    for (int i = 0; i < N; i++) begin
      rng = nextRng(rng); pat[i] = rng[3];
      pulse(pat[i]);
    end
    begin
      bit bad;
      bad = 0;
      for (int p = 0; p < N; p++) if (regQ[ord[p]] !== pat[N-1-p]) bad = 1;
      checks++;
      if (bad) begin errors++; $display("FAIL R5 preload image actual=%h expected chain pattern", regQ); end
    end
    // R4 held scanClk gives one shift only
    snap = regQ;
    scanDin = ~regQ[ord[0]]; scanClk = 1'b1; tick(5); scanClk = 1'b0; tick(2);
    check1("R4", regQ[ord[1]], snap[ord[0]], "single shift on held pulse");

    // R6 observe with loopback, FIFO order
    curReq = "R6";
    snap = regQ;
    for (int i = 0; i < N; i++) begin
      logic got;
      got = scanDout;
      if (i < 8) check1("R6", got, snap[ord[N-1-i]], "FIFO bit");
      pulse(got);
    end
    checks++; if (regQ !== snap) begin errors++; $display("FAIL R6 loopback image actual=%h expected=%h", regQ, snap); end

    // R9 functional load ignored in mode
    curReq = "R9";
    funcD = ~regQ; funcLoad = 1'b1; tick(1); funcLoad = 1'b0; tick(1);
    checks++; if (regQ !== snap) begin errors++; $display("FAIL R9 regQ actual=%h expected=%h", regQ, snap); end

    // R7 output disabled, shifting continues
    curReq = "R7";
    scanOeN = 1'b1; tick(1);
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    check1("R7", scanDoutEn, 1'b0, "oe high scanDoutEn");
    check1("R7", regQ[ord[2]], 1'b1, "shift under oe high");
    scanOeN = 1'b0; tick(1);

    // R3 exit blocked while funcLoad high
    curReq = "R3";
    funcLoad = 1'b1; scanMode = 1'b0; tick(3);
    check1("R3", scanDoutEn, 1'b1, "exit with funcLoad high");
    funcLoad = 1'b0; scanMode = 1'b1; tick(1);

    // R8 security lock
    curReq = "R8";
    secureLock = 1'b1; tick(1);
    check1("R8", scanDoutEn, 1'b0, "lock scanDoutEn");
    snap = regQ;
    pulse(~regQ[ord[0]]); pulse(1'b1);
    checks++; if (regQ !== snap) begin errors++; $display("FAIL R8 regQ actual=%h expected=%h", regQ, snap); end
    secureLock = 1'b0; scanMode = 1'b0; tick(2);
    check1("R8", scanDoutEn, 1'b0, "mode cleared after lock");
    scanMode = 1'b1; tick(2);
    check1("R8", scanDoutEn, 1'b1, "re-entry after lock");

    // R2 leave mode and load again
    curReq = "R2";
    scanMode = 1'b0; tick(2);
    funcD = {4{32'hA5C3_0F96}}; funcLoad = 1'b1; tick(1); funcLoad = 1'b0; tick(1);
    checks++; if (regQ !== funcD) begin errors++; $display("FAIL R2 reload actual=%h expected=%h", regQ, funcD); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule